// File: doc/BRIEF.md
# PRG-ROM Bank Translator

This block turns a CPU address in the upper part of the 64 KiB CPU space into a program ROM address, and says whether the access goes to the ROM or to work RAM. Software programs it by writing to decoded register addresses. Four 7-bit bank registers hold bank numbers. A mode register picks the bank granularity: one 32 KiB bank, two 16 KiB halves, four 8 KiB quarters, or four 8 KiB quarters with the bank number read bit-reversed. The same register controls whether the topmost bank is pinned to the last bank or taken from bank register 3, and whether the $6000-$7FFF window shows a ROM bank or work RAM. An outer-bank register supplies the two top ROM address bits.

Every bank number is masked to the outer bank size, which is a build parameter (128, 256 or 512 KiB). Register writes take effect on the clock edge that samples them. The address translation itself is combinational from the current address and register state. Reset is asserted asynchronously and released through a two-flop synchronizer.

Top module: `prg_xlat`

## Requirements
- R1: After reset, all registers are zero: 32 KiB mode, the top bank pinned to the last bank, and the $6000 window on work RAM. With a 512 KiB outer bank, address $8000 maps to ROM address $78000.
- R2: Registers are decoded with the address masked by $F803. Bank register n sits at $8000+n, the mode register at $D000 and the outer register at $D003. Writes with address bit 11 set change nothing. Addresses differing only in bits 10:2 alias.
- R3: Mode register bits 1:0 = 2 selects 8 KiB mode. Bank registers 0, 1, 2 and 3 drive $8000, $A000, $C000 and $E000 respectively.
- R4: Bits 1:0 = 1 selects 16 KiB mode. $8000-$BFFF uses bank register 1 × 2 + A13. $C000-$FFFF uses bank register 3 × 2 + A13.
- R5: Bits 1:0 = 0 selects 32 KiB mode. $8000-$FFFF uses bank register 3 × 4 + A14:A13.
- R6: Bits 1:0 = 3 behaves like 8 KiB mode, except that the 7-bit register value is bit-reversed (bit 0 swaps with bit 6, and so on) before masking. This also applies to the $6000 window.
- R7: When mode bit 2 is clear, the topmost bank ($8000, $C000 or $E000 in 32/16/8 KiB mode) is pinned to the last bank: all bank bits are ones within the outer width, with the address bits below the granularity passed through. When bit 2 is set, that bank comes from register 3.
- R8: When mode bit 7 is set, $6000-$7FFF maps an 8 KiB ROM bank from register 3. In 16 KiB mode this is reg × 2 + 1, and in 32 KiB mode it is reg × 4 + 3.
- R9: rom_sel is high for any address at or above $8000, and for $6000-$7FFF when mode bit 7 is set. wram_sel is high for $6000-$7FFF when mode bit 7 is clear. The two selects are never high together, and both are low below $6000. The ROM address is defined only while rom_sel is high.
- R10: The ROM address is formed as follows. Bits 12:0 follow the CPU address. The bank number is masked to log2(outer/8 KiB) bits and placed from bit 13 upward, with any bits up to bit 18 above it zero. Bits 20:19 come from outer register bits 2:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| prg_addr | output | 21 | Translated program ROM address |
| rom_sel | output | 1 | Program ROM chip select |
| wram_sel | output | 1 | Work RAM chip select |

## Verification
The assertions assume that cpu_addr, cpu_data and cpu_wr are stable around the rising edge. They also assume no register write is attempted during the two cycles while the synchronized reset is being released. The stimulus changes inputs only on the falling edge and waits several idle cycles after reset before the first write. The stability checks on configuration and outer bits are therefore tied to writes the bench actually issues, including writes with bit 11 set and aliased addresses.

// File: rtl/prg_xlat_pkg.sv
package prg_xlat_pkg;

  typedef enum logic [1:0] {
    PM_32K     = 2'd0,
    PM_16K     = 2'd1,
    PM_8K      = 2'd2,
    PM_8K_REV  = 2'd3
  } prg_mode_e;

  typedef struct packed {
    logic            win_rom;
    logic            top_sw;
    prg_mode_e       mode;
    logic [1:0]      outer;
    logic [3:0][6:0] bank;
  } prg_cfg_t;

  function automatic logic [6:0] rev7(input logic [6:0] v);
    logic [6:0] r;
    for (int i = 0; i < 7; i++) begin
      r[i] = v[6-i];
    end
    return r;
  endfunction

endpackage

// File: rtl/prg_rst_sync.sv
module prg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/prg_cfg_regs.sv
module prg_cfg_regs
  import prg_xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic        cpu_wr,
  output prg_cfg_t    cfg
);
  localparam logic [15:0] DEC_MASK  = 16'hF803;
  localparam logic [15:0] BANK_BASE = 16'h8000;
  localparam logic [15:0] MODE_ADDR = 16'hD000;
  localparam logic [15:0] OUTR_ADDR = 16'hD003;

  logic [15:0] dec;
  logic        hit_bank, hit_mode, hit_outr, cfg_en;
  prg_cfg_t    cfg_d, cfg_q;
  logic        unused_bits;

  assign dec      = cpu_addr & DEC_MASK;
  assign hit_bank = (dec[15:2] == BANK_BASE[15:2]);
  assign hit_mode = (dec == MODE_ADDR);
  assign hit_outr = (dec == OUTR_ADDR);
  assign cfg_en   = cpu_wr && (hit_bank || hit_mode || hit_outr);
  assign unused_bits = ^{dec[10:2], cpu_data[6:3]};

  always_comb begin
    cfg_d = cfg_q;
    if (hit_bank) begin
      cfg_d.bank[dec[1:0]] = cpu_data[6:0];
    end
    if (hit_mode) begin
      cfg_d.win_rom = cpu_data[7];
      cfg_d.top_sw  = cpu_data[2];
      cfg_d.mode    = prg_mode_e'(cpu_data[1:0]);
    end
    if (hit_outr) begin
      cfg_d.outer = cpu_data[2:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/prg_bank_sel.sv
module prg_bank_sel
  import prg_xlat_pkg::*;
#(
  parameter int IB = 6
) (
  input  prg_cfg_t      cfg,
  input  logic [15:13]  addr_hi,
  output logic [IB-1:0] bank_o
);
  logic       win, fixed;
  logic [1:0] slot;
  logic [6:0] pick, raw;

  assign win   = (addr_hi == 3'b011);
  assign slot  = addr_hi[14:13];
  assign fixed = !cfg.top_sw;

  always_comb begin
    pick = win ? cfg.bank[3] : cfg.bank[slot];
    if (cfg.mode == PM_8K_REV) pick = rev7(pick);
    unique case (cfg.mode)
      PM_32K: begin
        if (win)        raw = {cfg.bank[3][4:0], 2'b11};
        else if (fixed) raw = {5'h1F, slot};
        else            raw = {cfg.bank[3][4:0], slot};
      end
      PM_16K: begin
        if (win)           raw = {cfg.bank[3][5:0], 1'b1};
        else if (!slot[1]) raw = {cfg.bank[1][5:0], slot[0]};
        else if (fixed)    raw = {6'h3F, slot[0]};
        else               raw = {cfg.bank[3][5:0], slot[0]};
      end
      default: begin
        if (!win && slot == 2'd3 && fixed) raw = 7'h7F;
        else                               raw = pick;
      end
    endcase
  end

  assign bank_o = raw[IB-1:0];
endmodule

// File: rtl/prg_cs_dec.sv
module prg_cs_dec (
  input  logic [15:13] addr_hi,
  input  logic         win_rom,
  output logic         rom_sel,
  output logic         wram_sel
);
  logic in_win;
  assign in_win   = (addr_hi == 3'b011);
  assign rom_sel  = addr_hi[15] || (in_win && win_rom);
  assign wram_sel = in_win && !win_rom;
endmodule

// File: rtl/prg_xlat.sv
module prg_xlat
  import prg_xlat_pkg::*;
#(
  parameter int OUTER_KB = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic        cpu_wr,
  output logic [20:0] prg_addr,
  output logic        rom_sel,
  output logic        wram_sel
);
  localparam int IB     = (OUTER_KB == 128) ? 4 : (OUTER_KB == 256) ? 5 : 6;
  localparam int BANK_W = 6;

  logic          rst_core_n;
  prg_cfg_t      cfg;
  logic [IB-1:0] bank;
  logic [BANK_W-1:0] bank_field;

  prg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n)
  );

  prg_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_core_n), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .cpu_wr(cpu_wr), .cfg(cfg)
  );

  prg_bank_sel #(.IB(IB)) u_bank (
    .cfg(cfg), .addr_hi(cpu_addr[15:13]), .bank_o(bank)
  );

  prg_cs_dec u_cs (
    .addr_hi(cpu_addr[15:13]), .win_rom(cfg.win_rom),
    .rom_sel(rom_sel), .wram_sel(wram_sel)
  );

  generate
    if (IB < BANK_W) begin : g_pad
      assign bank_field = {{(BANK_W-IB){1'b0}}, bank};
    end else begin : g_full
      assign bank_field = bank;
    end
  endgenerate

  assign prg_addr = {cfg.outer, bank_field, cpu_addr[12:0]};
endmodule

// File: rtl/prg_xlat_chk.sv
module prg_xlat_chk
  import prg_xlat_pkg::*;
#(
  parameter int IB = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_wr,
  input logic [20:0] prg_addr,
  input logic        rom_sel,
  input logic        wram_sel,
  input prg_cfg_t    cfg
);
  logic wr_outer;
  logic unused_chk;
  assign wr_outer   = cpu_wr && ((cpu_addr & 16'hF803) == 16'hD003);
  assign unused_chk = ^prg_addr[18:13+IB];

  a_r9_cs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_sel && wram_sel));

  a_r9_upper_rom: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[15] |-> rom_sel);

  a_r9_wram_window: assert property (@(posedge clk) disable iff (!rst_n)
    wram_sel |-> (cpu_addr[15:13] == 3'b011));

  a_r2_bit11_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[11]) |=> $stable(cfg));

  a_r10_outer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_outer |=> $stable(prg_addr[20:19]));

  a_r10_low_pass: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> (prg_addr[12:0] == cpu_addr[12:0]));

  a_r7_fixed_top: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.top_sw && cfg.mode[1] && cpu_addr[15:13] == 3'b111)
      |-> (prg_addr[13+IB-1:13] == {IB{1'b1}}));
endmodule

bind prg_xlat prg_xlat_chk #(.IB(IB)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
  .prg_addr(prg_addr), .rom_sel(rom_sel), .wram_sel(wram_sel), .cfg(cfg)
);

// File: tb/prg_xlat_bench.sv
`timescale 1ns/1ps
module prg_xlat_bench;
  localparam int OKB = 512;
  localparam int IB  = (OKB == 128) ? 4 : (OKB == 256) ? 5 : 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_data;
  logic        cpu_wr;
  logic [20:0] prg_addr;
  logic        rom_sel, wram_sel;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  int bk[4];
  int mode;
  int outer;

  always #10 clk = ~clk;

  prg_xlat #(.OUTER_KB(OKB)) u_prg_xlat (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .prg_addr(prg_addr), .rom_sel(rom_sel), .wram_sel(wram_sel)
  );

  function automatic int rev(input int v);
    int r = 0;
    for (int i = 0; i < 7; i++) if ((v >> i) & 1) r |= 1 << (6 - i);
    return r;
  endfunction

  function automatic int model_bank(input int a);
    int m = mode & 3;
    bit fx = ((mode & 4) == 0);
    bit win = (a >= 'h6000 && a < 'h8000);
    int q = (a >> 13) & 3;
    int b;
    if (win) begin
      if (m == 0)      b = bk[3] * 4 + 3;
      else if (m == 1) b = bk[3] * 2 + 1;
      else if (m == 2) b = bk[3];
      else             b = rev(bk[3]);
    end else if (m == 0) begin
      b = (fx ? 127 : bk[3]) * 4 + q;
    end else if (m == 1) begin
      if (a < 'hC000) b = bk[1] * 2 + (q & 1);
      else            b = (fx ? 127 : bk[3]) * 2 + (q & 1);
    end else begin
      if (q == 3 && fx) b = 127;
      else              b = (m == 3) ? rev(bk[q]) : bk[q];
    end
    return b & ((1 << IB) - 1);
  endfunction

  task automatic model_write(input int a, input int d);
    int s = a & 'hF803;
    if (s >= 'h8000 && s <= 'h8003) bk[s & 3] = d & 'h7F;
    else if (s == 'hD000) mode = d & 'h87;
    else if (s == 'hD003) outer = (d >> 1) & 3;
  endtask

  task automatic check(input int a, input string tag);
    bit ewin = (a >= 'h6000 && a < 'h8000);
    bit erom = (a >= 'h8000) || (ewin && (mode & 'h80));
    bit ewr  = ewin && !(mode & 'h80);
    int ea   = (outer << 19) | (model_bank(a) << 13) | (a & 'h1FFF);
    vectors++;
    if (rom_sel !== erom || wram_sel !== ewr || (erom && prg_addr !== ea[20:0])) begin
      errors++;
      $display("FAIL %s addr=%h: got rom=%0b wram=%0b prg=%h, expected rom=%0b wram=%0b prg=%h",
               tag, a[15:0], rom_sel, wram_sel, prg_addr, erom, ewr, ea[20:0]);
    end
  endtask

  task automatic step(input int a, input int d, input bit w, input string tag);
    @(negedge clk);
    cpu_addr = a[15:0]; cpu_data = d[7:0]; cpu_wr = w;
    #5;
    check(a, tag);
    @(posedge clk);
    if (w) model_write(a, d);
  endtask

  task automatic wr(input int a, input int d, input string tag);
    step(a, d, 1'b1, tag);
  endtask

  task automatic sweep(input string tag);
    int pts[11] = '{'h1234, 'h6000, 'h7FFF, 'h8000, 'h9FFF, 'hA000,
                    'hBFFF, 'hC000, 'hDFFF, 'hE000, 'hFFFF};
    foreach (pts[i]) step(pts[i], 0, 1'b0, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) bk[i] = 0;
    mode = 0; outer = 0;
    rst_n = 1'b0; cpu_addr = '0; cpu_data = '0; cpu_wr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state; $8000 -> $78000
    step('h8000, 0, 1'b0, "R1");
    if (prg_addr !== 21'h78000) begin
      errors++;
      $display("FAIL R1 reset map: got %h expected %h", prg_addr, 21'h78000);
    end
    sweep("R1");
    repeat (4) @(posedge clk);

    // R3: 8 KiB mode, top switchable
    wr('hD000, 'h06, "R3");
    wr('h8000, 'h01, "R3"); wr('h8001, 'h02, "R3");
    wr('h8002, 'h03, "R3"); wr('h8003, 'h04, "R3");
    sweep("R3");
    // R2: bit 11 set ignored, aliased address accepted
    wr('h8800, 'h15, "R2"); wr('hD800, 'h01, "R2"); wr('hD803, 'h06, "R2");
    sweep("R2");
    wr('h87F4, 'h11, "R2"); wr('hD7FB, 'h02, "R2");
    sweep("R2");
    // R7: pinned top in 8 KiB mode
    wr('hD000, 'h02, "R7");
    sweep("R7");
    // R6: reversed bank numbers
    wr('h8000, 'h01, "R6"); wr('h8001, 'h02, "R6");
    wr('h8002, 'h04, "R6"); wr('h8003, 'h08, "R6");
    wr('hD000, 'h07, "R6");
    sweep("R6");
    wr('hD000, 'h03, "R6");
    sweep("R6");
    // R4: 16 KiB mode
    wr('h8001, 'h05, "R4"); wr('h8003, 'h09, "R4");
    wr('hD000, 'h05, "R4");
    sweep("R4");
    wr('hD000, 'h01, "R7");
    sweep("R7");
    // R5: 32 KiB mode
    wr('h8003, 'h06, "R5");
    wr('hD000, 'h04, "R5");
    sweep("R5");
    wr('hD000, 'h00, "R7");
    sweep("R7");
    // R8 / R9: ROM window in every mode
    for (int m = 0; m < 4; m++) begin
      wr('hD000, 'h84 | m, "R8");
      sweep("R8");
    end
    wr('hD000, 'h06, "R9");
    step('h6000, 0, 1'b0, "R9"); step('h5FFF, 0, 1'b0, "R9");
    // R10: masking and outer bits
    wr('h8000, 'h7F, "R10"); wr('h8002, 'h45, "R10");
    wr('hD003, 'h06, "R10");
    sweep("R10");
    wr('hD003, 'h02, "R10");
    sweep("R10");
    wr('hD003, 'h04, "R10");
    wr('hD000, 'h87, "R10");
    sweep("R10");

    @(negedge clk) cpu_wr = 1'b0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule